// File: doc/BRIEF.md
# Segmented Address Extension Unit

This unit sits beside a processor core and widens its 32-bit logical addresses into 36-bit physical addresses. The mapping comes from a bank of programmable segments. Each segment is described by four fields: a logical base, a size code that sets a power-of-two span, a physical replacement base, and six permission bits. A request arrives with an address, an access kind and a privilege level. It is checked against every segment at once. The unit returns either the translated address with a hit flag, or a fault flag.

Software programs the segments through a word-wide register port. Writes land on the next clock edge, and reads are combinational. Coming out of reset, two segments are already live. The lower 2 GB of logical space maps onto itself. The upper 2 GB maps onto physical 0x8_0000_0000.

Top module: `seg_xlate`

## Requirements
- R1: After reset, segment 0 covers logical 0x0000_0000..0x7FFF_FFFF, mapped to physical 0x0_0000_0000 with all permissions (low word 0x0000_003F, high word 0x0000_001E). Segment 1 covers 0x8000_0000..0xFFFF_FFFF, mapped to 0x8_0000_0000 with all permissions (low 0x8000_003F, high 0x8000_001E). Every other segment reads back zero.
- R2: Reserved bits read back as zero. These are bits 11:5 of a high word and bits 7:6 of a low word.
- R3: Segment n owns two register words. Word index 2n is the low word, at byte offset 8n: replacement base in bits 31:8 (physical address bits 35:12) and permissions in bits 5:0. Word index 2n+1 is the high word: logical base in bits 31:12 (logical address bits 31:12) and size code in bits 4:0.
- R4: A segment with size code c spans 2^(c+1) bytes. It matches when the logical address agrees with the base on bits 31 down to c+1. Code 31 therefore matches every address.
- R5: A size code below 11 disables its segment, and a disabled segment never matches.
- R6: On a hit, physical bits above the segment offset come from the replacement base, and the lower c+1 bits are the untouched logical bits.
- R7: When several segments match, the highest-numbered one decides both the translation and the permissions.
- R8: Permission bits are, from bit 0 up: user read, user write, user execute, supervisor read, supervisor write, supervisor execute. The access kind is encoded as 0 read, 1 write, 2 execute. A kind of 3, or a kind the winning segment does not grant at the request's privilege, faults.
- R9: A valid request that matches no segment faults. Whenever the fault flag is set, the physical address output is zero.
- R10: A register write changes translations only from the clock edge that stores it. A request in the same cycle as the write still sees the old mapping.
- R11: With no valid request, both hit and fault stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 5 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_word |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_sup | input | 1 | 1 for supervisor, 0 for user |
| xl_hit | output | 1 | Translation succeeded |
| xl_fault | output | 1 | No match or permission denied |
| xl_paddr | output | 36 | Physical address, zero unless hit |

## Verification
Some properties are checked by assertions on every cycle:
- reserved bits reading back zero;
- a written field appearing on the following edge and staying put otherwise;
- a disabled segment never matching;
- the offset bits passing through on a match;
- a fault coming with a zero address;
- an idle request staying quiet;
- the top segment winning whenever it matches.

Other behaviour only the directed scenarios can show:
- the exact reset mapping;
- the span chosen by each size code, including the 4 KB and 4 GB extremes;
- the priority among overlapping lower segments;
- each of the six permission bits against every access kind and privilege;
- the old mapping still applying in the very cycle of a write.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int unsigned LA_W     = 32;
  localparam int unsigned PA_W     = 36;
  localparam int unsigned PAGE_W   = 12;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned PERM_W   = 6;
  localparam int unsigned MIN_CODE = 11;
  localparam int unsigned BASE_W   = LA_W - PAGE_W;
  localparam int unsigned REPL_W   = PA_W - PAGE_W;
  localparam int unsigned HI_GAP   = PAGE_W - CODE_W;
  localparam int unsigned LO_GAP   = LA_W - REPL_W - PERM_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  function automatic logic [BASE_W-1:0] rst_base(input int s);
    return (s == 1) ? BASE_W'(32'h8_0000) : '0;
  endfunction

  function automatic logic [CODE_W-1:0] rst_code(input int s);
    return (s < 2) ? CODE_W'(30) : '0;
  endfunction

  function automatic logic [REPL_W-1:0] rst_repl(input int s);
    return (s == 1) ? REPL_W'(32'h80_0000) : '0;
  endfunction

  function automatic logic [PERM_W-1:0] rst_perm(input int s);
    return (s < 2) ? '1 : '0;
  endfunction

endpackage

// File: rtl/seg_regs.sv
module seg_regs
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NSEG = 16,
  localparam int unsigned IDX_W = $clog2(2 * NSEG),
  localparam int unsigned SEL_W = IDX_W - 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             word,
  input  logic [LA_W-1:0]              wdata,
  output logic [LA_W-1:0]              rdata,
  output logic [NSEG-1:0][BASE_W-1:0]  base_o,
  output logic [NSEG-1:0][CODE_W-1:0]  code_o,
  output logic [NSEG-1:0][REPL_W-1:0]  repl_o,
  output logic [NSEG-1:0][PERM_W-1:0]  perm_o
);

  logic [NSEG-1:0][BASE_W-1:0] base_q, base_d;
  logic [NSEG-1:0][CODE_W-1:0] code_q, code_d;
  logic [NSEG-1:0][REPL_W-1:0] repl_q, repl_d;
  logic [NSEG-1:0][PERM_W-1:0] perm_q, perm_d;
  logic [SEL_W-1:0]            sel;
  logic                        is_hi;

  assign sel   = word[IDX_W-1:1];
  assign is_hi = word[0];

  // next-state
  always_comb begin
    base_d = base_q;
    code_d = code_q;
    repl_d = repl_q;
    perm_d = perm_q;
    if (we) begin
      if (is_hi) begin
        base_d[sel] = wdata[LA_W-1:PAGE_W];
        code_d[sel] = wdata[CODE_W-1:0];
      end else begin
        repl_d[sel] = wdata[LA_W-1:LA_W-REPL_W];
        perm_d[sel] = wdata[PERM_W-1:0];
      end
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(NSEG); s++) begin
        base_q[s] <= rst_base(s);
        code_q[s] <= rst_code(s);
        repl_q[s] <= rst_repl(s);
        perm_q[s] <= rst_perm(s);
      end
    end else if (we) begin
      base_q <= base_d;
      code_q <= code_d;
      repl_q <= repl_d;
      perm_q <= perm_d;
    end
  end

  // readback with reserved bits forced low
  always_comb begin
    if (is_hi) rdata = {base_q[sel], HI_GAP'(0), code_q[sel]};
    else       rdata = {repl_q[sel], LO_GAP'(0), perm_q[sel]};
  end

  assign base_o = base_q;
  assign code_o = code_q;
  assign repl_o = repl_q;
  assign perm_o = perm_q;

  p_rsvd_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_hi |-> (rdata[PAGE_W-1:CODE_W] == '0));

  p_rsvd_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_hi |-> (rdata[PERM_W+LO_GAP-1:PERM_W] == '0));

  p_code_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_hi) |=> (code_q[$past(sel)] == $past(wdata[CODE_W-1:0])));

  p_perm_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !is_hi) |=> (perm_q[$past(sel)] == $past(wdata[PERM_W-1:0])));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(code_q) && $stable(base_q) && $stable(repl_q) && $stable(perm_q)));

endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   vaddr,
  input  logic [BASE_W-1:0] base,
  input  logic [CODE_W-1:0] code,
  input  logic [REPL_W-1:0] repl,
  output logic              match,
  output logic [PA_W-1:0]   paddr
);

  localparam int unsigned EXT_W = PA_W - LA_W;

  logic              en;
  logic [5:0]        nbits;
  logic [LA_W:0]     one_sh;
  logic [LA_W:0]     span;
  logic [LA_W-1:0]   lo_mask;
  logic [LA_W-1:0]   base_full;
  logic [PA_W-1:0]   repl_full;
  logic [PA_W-1:0]   lo_mask_pa;

  assign en         = (code >= CODE_W'(MIN_CODE));
  assign nbits      = 6'(code) + 6'd1;
  assign one_sh     = (LA_W+1)'(1) << nbits;
  assign span       = one_sh - (LA_W+1)'(1);
  assign lo_mask    = span[LA_W-1:0];
  assign base_full  = {base, PAGE_W'(0)};
  assign repl_full  = {repl, PAGE_W'(0)};
  assign lo_mask_pa = {EXT_W'(0), lo_mask};

  assign match = en && ((vaddr & ~lo_mask) == (base_full & ~lo_mask));
  assign paddr = (repl_full & ~lo_mask_pa) | {EXT_W'(0), vaddr & lo_mask};

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code < CODE_W'(MIN_CODE)) |-> !match);

  p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (paddr[PAGE_W-1:0] == vaddr[PAGE_W-1:0]));

endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NSEG = 16,
  localparam int unsigned SEL_W = $clog2(NSEG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid,
  input  acc_e                        acc,
  input  logic                        sup,
  input  logic [NSEG-1:0]             match,
  input  logic [NSEG-1:0][PA_W-1:0]   cand,
  input  logic [NSEG-1:0][PERM_W-1:0] perm,
  output logic                        hit,
  output logic                        fault,
  output logic [PA_W-1:0]             paddr
);

  logic             any;
  logic [SEL_W-1:0] win;
  logic [7:0]       pvec;
  logic [2:0]       pidx;
  logic             allowed;

  // last matching index wins
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int s = 0; s < int'(NSEG); s++) begin
      if (match[s]) begin
        any = 1'b1;
        win = SEL_W'(s);
      end
    end
  end

  assign pvec    = {(8 - PERM_W)'(0), perm[win]};
  assign pidx    = (sup ? 3'd3 : 3'd0) + {1'b0, acc};
  assign allowed = (acc != ACC_RSVD) && pvec[pidx];

  assign hit   = valid && any && allowed;
  assign fault = valid && !hit;
  assign paddr = hit ? cand[win] : '0;

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (paddr == '0));

  p_rsvd_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && acc == ACC_RSVD) |-> fault);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!hit && !fault));

  p_top_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && match[NSEG-1]) |-> (paddr == cand[NSEG-1]));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NSEG = 16,
  localparam int unsigned IDX_W = $clog2(2 * NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_word,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_sup,
  output logic             xl_hit,
  output logic             xl_fault,
  output logic [35:0]      xl_paddr
);

  logic rst_s1, rst_s2;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [NSEG-1:0][BASE_W-1:0] base;
  logic [NSEG-1:0][CODE_W-1:0] code;
  logic [NSEG-1:0][REPL_W-1:0] repl;
  logic [NSEG-1:0][PERM_W-1:0] perm;
  logic [NSEG-1:0]             match;
  logic [NSEG-1:0][PA_W-1:0]   cand;

  seg_regs #(.NSEG(NSEG)) i_regs (
    .clk    (clk),
    .rst_n  (rst_s2),
    .we     (reg_we),
    .word   (reg_word),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .base_o (base),
    .code_o (code),
    .repl_o (repl),
    .perm_o (perm)
  );

  for (genvar g = 0; g < int'(NSEG); g++) begin : g_seg
    seg_match i_match (
      .clk   (clk),
      .rst_n (rst_s2),
      .vaddr (req_vaddr),
      .base  (base[g]),
      .code  (code[g]),
      .repl  (repl[g]),
      .match (match[g]),
      .paddr (cand[g])
    );
  end

  seg_pick #(.NSEG(NSEG)) i_pick (
    .clk   (clk),
    .rst_n (rst_s2),
    .valid (req_valid),
    .acc   (acc_e'(req_acc)),
    .sup   (req_sup),
    .match (match),
    .cand  (cand),
    .perm  (perm),
    .hit   (xl_hit),
    .fault (xl_fault),
    .paddr (xl_paddr)
  );

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_s2)
    !(xl_hit && xl_fault));

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_word;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_sup;
  logic        xl_hit;
  logic        xl_fault;
  logic [35:0] xl_paddr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  seg_xlate i_seg_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_word  (reg_word),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_acc   (req_acc),
    .req_sup   (req_sup),
    .xl_hit    (xl_hit),
    .xl_fault  (xl_fault),
    .xl_paddr  (xl_paddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string rq, input logic [4:0] w, input logic [31:0] exp);
    @(negedge clk);
    reg_word = w;
    #1 chk(rq, 64'(reg_rdata), 64'(exp));
  endtask

  // expected: {hit, fault, paddr}
  task automatic xl(input string rq, input logic [31:0] va, input logic [1:0] acc,
                    input logic sup, input logic eh, input logic [35:0] ep);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_sup = sup;
    #1 chk(rq, {26'b0, xl_hit, xl_fault, xl_paddr}, {26'b0, eh, !eh, eh ? ep : 36'h0});
  endtask

  task automatic t_reset;
    rd("R1 seg0 low", 5'd0, 32'h0000_003F);
    rd("R1 seg0 high", 5'd1, 32'h0000_001E);
    rd("R1 seg1 low", 5'd2, 32'h8000_003F);
    rd("R1 seg1 high", 5'd3, 32'h8000_001E);
    rd("R1 seg15 low", 5'd30, 32'h0);
    rd("R1 seg15 high", 5'd31, 32'h0);
    xl("R1 lower identity", 32'h1234_5678, 2'd0, 1'b0, 1'b1, 36'h0_1234_5678);
    xl("R1 upper to 8_", 32'h9000_0004, 2'd1, 1'b1, 1'b1, 36'h8_1000_0004);
    xl("R1 top edge", 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b1, 36'h8_7FFF_FFFF);
  endtask

  task automatic t_reserved;
    wr(5'd5, 32'hFFFF_FFFF);
    rd("R2 high reserved", 5'd5, 32'hFFFF_F01F);
    rd("R3 low untouched by high write", 5'd4, 32'h0);
    wr(5'd4, 32'hFFFF_FFFF);
    rd("R2 low reserved", 5'd4, 32'hFFFF_FF3F);
    wr(5'd5, 32'h0);
    wr(5'd4, 32'h0);
    rd("R3 seg2 low cleared", 5'd4, 32'h0);
  endtask

  task automatic t_size;
    wr(5'd4, 32'h1210_103F);
    wr(5'd5, 32'h2101_000B);
    rd("R3 seg2 high", 5'd5, 32'h2101_000B);
    xl("R6 4KB hit", 32'h2101_0ABC, 2'd0, 1'b0, 1'b1, 36'h1_2101_0ABC);
    xl("R4 4KB last byte", 32'h2101_0FFF, 2'd0, 1'b0, 1'b1, 36'h1_2101_0FFF);
    xl("R4 just past 4KB", 32'h2101_1000, 2'd0, 1'b0, 1'b1, 36'h0_2101_1000);
    xl("R4 just before 4KB", 32'h2100_FFFF, 2'd0, 1'b0, 1'b1, 36'h0_2100_FFFF);
    wr(5'd5, 32'h2101_000C);
    xl("R4 8KB covers second page", 32'h2101_1004, 2'd0, 1'b0, 1'b1, 36'h1_2101_1004);
    wr(5'd5, 32'h2101_000A);
    xl("R5 code 10 disabled", 32'h2101_0ABC, 2'd0, 1'b0, 1'b1, 36'h0_2101_0ABC);
    wr(5'd5, 32'h2101_000B);
  endtask

  task automatic t_priority;
    wr(5'd6, 32'h3000_003F);
    wr(5'd7, 32'h2101_000B);
    xl("R7 seg3 over seg2", 32'h2101_0ABC, 2'd0, 1'b0, 1'b1, 36'h3_0000_0ABC);
    wr(5'd8, 32'h4000_003F);
    wr(5'd9, 32'h2100_0010);
    xl("R7 seg4 wide wins", 32'h2101_0ABC, 2'd0, 1'b0, 1'b1, 36'h4_0001_0ABC);
    xl("R4 outside 128KB", 32'h2102_0000, 2'd0, 1'b0, 1'b1, 36'h0_2102_0000);
    wr(5'd9, 32'h0);
    xl("R7 back to seg3", 32'h2101_0ABC, 2'd0, 1'b0, 1'b1, 36'h3_0000_0ABC);
  endtask

  task automatic t_perm;
    wr(5'd10, 32'h0000_5011);
    wr(5'd11, 32'h4000_000B);
    xl("R8 user read ok", 32'h4000_0123, 2'd0, 1'b0, 1'b1, 36'h0_0005_0123);
    xl("R8 user write denied", 32'h4000_0123, 2'd1, 1'b0, 1'b0, 36'h0);
    xl("R8 user exec denied", 32'h4000_0123, 2'd2, 1'b0, 1'b0, 36'h0);
    xl("R8 sup read denied", 32'h4000_0123, 2'd0, 1'b1, 1'b0, 36'h0);
    xl("R8 sup write ok", 32'h4000_0123, 2'd1, 1'b1, 1'b1, 36'h0_0005_0123);
    xl("R8 sup exec denied", 32'h4000_0123, 2'd2, 1'b1, 1'b0, 36'h0);
    xl("R8 kind 3 denied", 32'h4000_0123, 2'd3, 1'b1, 1'b0, 36'h0);
    xl("R8 kind 3 on full perms", 32'h1000_0000, 2'd3, 1'b0, 1'b0, 36'h0);
  endtask

  task automatic t_nomatch;
    wr(5'd1, 32'h0);
    xl("R9 no segment", 32'h1000_0000, 2'd0, 1'b1, 1'b0, 36'h0);
    xl("R9 seg1 still maps", 32'h9000_0000, 2'd0, 1'b1, 1'b1, 36'h8_1000_0000);
    wr(5'd1, 32'h0000_001E);
    xl("R9 restored", 32'h1000_0000, 2'd0, 1'b1, 1'b1, 36'h0_1000_0000);
  endtask

  task automatic t_timing;
    wr(5'd12, 32'hF000_003F);
    @(negedge clk);
    reg_we = 1'b1; reg_word = 5'd13; reg_wdata = 32'h0000_001F;
    req_valid = 1'b1; req_vaddr = 32'h1234_5678; req_acc = 2'd0; req_sup = 1'b0;
    #1 chk("R10 same cycle old map", {27'b0, xl_hit, xl_paddr}, {27'b0, 1'b1, 36'h0_1234_5678});
    @(negedge clk);
    reg_we = 1'b0;
    #1 chk("R10 next cycle new map", {27'b0, xl_hit, xl_paddr}, {27'b0, 1'b1, 36'hF_1234_5678});
    xl("R4 code 31 whole space", 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 36'hF_FFFF_FFFF);
    wr(5'd13, 32'h0);
    xl("R10 seg6 removed", 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 36'h8_7FFF_FFFF);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'h1000_0000; req_acc = 2'd0;
    #1 chk("R11 idle in-range", {62'b0, xl_hit, xl_fault}, 64'h0);
    req_vaddr = 32'h4000_0000; req_acc = 2'd3;
    #1 chk("R11 idle bad kind", {62'b0, xl_hit, xl_fault}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_word = '0; reg_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_sup = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_reserved;
    t_size;
    t_priority;
    t_perm;
    t_nomatch;
    t_timing;
    t_idle;
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule